// File: doc/BRIEF.md
# Real-Time Clock Control and Interrupt Flags

This block is the control and status core of a PC-style battery-backed clock. A host reaches it through two byte ports. A write to the index port selects a location. A read or write on the data port then reaches that location. The locations are a seconds counter, an alarm-seconds byte, four control/status registers (A at index 10, B at 11, C at 12, D at 13) and general byte storage at every other index.

A reference tick, normally 32.768 kHz, drives a binary divider chain of `TICKS_LOG2` stages. The divider produces a selectable periodic event, which sets a flag and can toggle a square-wave pin. When the chain wraps, the block runs a once-per-second update. An update-in-progress indication warns the host before the seconds value changes and stays up while the update settles. Interrupt flags collect in register C, a summary bit drives the interrupt pin, and the whole register clears when the host reads it.

Top module: `rtc_ctrl`

## Requirements
- R1: A write with `bus_sel`=0 loads the index. A write with `bus_sel`=1 stores into the indexed location. A read strobe returns data on `bus_rdata` at the next clock edge: the index itself when `bus_sel`=0, and the indexed location when `bus_sel`=1. Every index other than 0, 1 and 10–13 is a plain byte store.
- R2: After reset, A reads 0x26, B reads 0x02, C reads 0x00 and D reads 0x80. `irq`, `sqw` and `bus_rdata` are 0.
- R3: Register A bit 7 reads the update-in-progress state, and writes to that bit are ignored. Bits 6:0 read back as written.
- R4: Register A bits 3:0 (rate n) select the periodic event. For n from 1 to 15, the event occurs every 2^(n-1) reference ticks, capped at one full divider cycle. For n = 0, no event occurs.
- R5: A divider code of 110 or 111 in A bits 6:4 holds the divider at zero. While held, there are no periodic events, no update, and update-in-progress is low. The divider restarts when any other code is written.
- R6: Update-in-progress rises `LEAD_TICKS` ticks before the divider wraps and falls `UPD_TICKS` ticks after the wrap. It is high for `LEAD_TICKS`+`UPD_TICKS` ticks in total. The seconds value changes only at the wrap, inside the window.
- R7: At the wrap, seconds (index 0) advances by one modulo 60. The count is BCD when B bit 2 is 0 and binary when B bit 2 is 1.
- R8: While B bit 7 is set, no update starts, a running update is dropped within one clock, update-in-progress stays low, seconds holds, and no update-ended flag sets.
- R9: C bit 6 sets on every periodic event. C bit 4 sets when an update ends. C bit 5 sets when an update ends with seconds equal to the alarm byte (index 1). All three set whatever the enable bits hold.
- R10: C bit 7 is high when a flag is set together with its enable: bit 6 with B bit 6, bit 5 with B bit 5, bit 4 with B bit 4. `irq` equals C bit 7.
- R11: Reading C returns its contents and clears all of its bits at the same clock edge.
- R12: Register D reads 0x80 at all times, and writes to D are ignored.
- R13: With B bit 3 set and a nonzero rate, `sqw` toggles on each periodic event. Otherwise `sqw` is held low.

Port order follows the port list of `rtc_ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-clock enable per reference period |
| bus_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |
| sqw | output | 1 | Square-wave output |

## Verification
The properties assume the following about the inputs:
- `ref_tick` is a single-clock enable.
- Write and read strobes are never asserted in the same cycle.
- `LEAD_TICKS` is at least one and smaller than a divider cycle.

The bench holds `ref_tick` high on every clock, so ticks and cycles coincide. It issues one bus operation per cycle. It sets the halt bit while it loads the seconds and alarm bytes, so that no update can race a host write. It shortens the divider to 12 stages so that several update cycles fit in the run.

// File: rtl/rtc_pkg.sv
// Shared constants, types and helpers for the real-time clock control core.
// Assumes an index space no wider than 8 bits.
package rtc_pkg;

    // Decoded indices; other indices are plain byte storage
    localparam int IDX_SEC = 0;
    localparam int IDX_ALM = 1;
    localparam int IDX_A   = 10;
    localparam int IDX_B   = 11;
    localparam int IDX_C   = 12;
    localparam int IDX_D   = 13;

    // Register B bit positions
    localparam int B_HALT = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int B_SQWE = 3;
    localparam int B_BIN  = 2;

    localparam logic [6:0] A_RST = 7'h26;
    localparam logic [7:0] B_RST = 8'h02;
    localparam logic [7:0] D_VAL = 8'h80;

    typedef enum logic [1:0] {
        UPD_IDLE,
        UPD_LEAD,
        UPD_BUSY
    } upd_state_e;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } flag_t;

    // Next seconds value, modulo 60, binary or BCD
    function automatic logic [7:0] sec_next(input logic [7:0] s, input logic bin);
        logic [7:0] r;
        if (bin) begin
            r = (s >= 8'd59) ? 8'd0 : s + 8'd1;
        end else if (s[3:0] >= 4'd9) begin
            r = (s[7:4] >= 4'd5) ? 8'h00 : {s[7:4] + 4'd1, 4'h0};
        end else begin
            r = {s[7:4], s[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_divider.sv
// Divider chain clocked by the reference tick.
// Produces the periodic event, the lead-window start and the wrap strobe.
// Assumes ref_tick is high for one clock per reference period.
module rtc_divider #(
    parameter int TICKS_LOG2 = 15,
    parameter int LEAD_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic [2:0] div_sel,
    input  logic [3:0] rate,
    output logic       running,
    output logic       per_pulse,
    output logic       lead_hit,
    output logic       wrap_hit
);

    localparam logic [TICKS_LOG2-1:0] CNT_MAX = '1;
    localparam logic [TICKS_LOG2-1:0] CNT_ONE = TICKS_LOG2'(1);
    localparam logic [TICKS_LOG2-1:0] LEAD_AT = CNT_MAX - TICKS_LOG2'(LEAD_TICKS);

    logic [TICKS_LOG2-1:0] div_cnt;
    logic [TICKS_LOG2-1:0] cnt_inc;
    logic [TICKS_LOG2-1:0] rate_mask;
    logic [3:0]            shift;

    assign running = (div_sel != 3'b110) && (div_sel != 3'b111);
    assign cnt_inc = div_cnt + CNT_ONE;
    assign shift   = rate - 4'd1;

    // Mask of low counter bits that must roll to zero for an event
    always_comb begin
        if (int'(shift) >= TICKS_LOG2) begin
            rate_mask = '1;
        end else begin
            rate_mask = (CNT_ONE << shift) - CNT_ONE;
        end
    end

    assign per_pulse = ref_tick && running && (rate != 4'd0) && ((cnt_inc & rate_mask) == '0);
    assign lead_hit  = ref_tick && running && (div_cnt == LEAD_AT);
    assign wrap_hit  = ref_tick && running && (div_cnt == CNT_MAX);

    // Divider counter: cleared while held, advances on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            div_cnt <= '0;
        end else if (ref_tick) begin
            div_cnt <= cnt_inc;
        end
    end

endmodule

// File: rtl/rtc_update.sv
// Update-cycle sequencer.
// Raises the in-progress state at the lead point, steps the seconds at the
// wrap and reports completion after UPD_TICKS ticks.
// Assumes lead_hit precedes wrap_hit within one divider cycle.
module rtc_update
    import rtc_pkg::*;
#(
    parameter int UPD_TICKS = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic running,
    input  logic halt,
    input  logic lead_hit,
    input  logic wrap_hit,
    output logic uip,
    output logic sec_step,
    output logic upd_done
);

    localparam int CW = $clog2(UPD_TICKS + 1);
    localparam logic [CW-1:0] BUSY_LAST = CW'(UPD_TICKS - 1);

    upd_state_e state;
    logic [CW-1:0] busy_cnt;
    logic blocked;

    assign blocked  = halt || !running;
    assign uip      = (state != UPD_IDLE);
    assign sec_step = !blocked && (state == UPD_LEAD) && wrap_hit;
    assign upd_done = !blocked && (state == UPD_BUSY) && ref_tick && (busy_cnt == BUSY_LAST);

    // Sequencer state and busy-window tick count
    always_ff @(posedge clk) begin
        if (!rst_n || blocked) begin
            state    <= UPD_IDLE;
            busy_cnt <= '0;
        end else begin
            case (state)
                UPD_IDLE: if (lead_hit) state <= UPD_LEAD;
                UPD_LEAD: if (wrap_hit) begin
                    state    <= UPD_BUSY;
                    busy_cnt <= '0;
                end
                UPD_BUSY: if (ref_tick) begin
                    if (busy_cnt == BUSY_LAST) state <= UPD_IDLE;
                    else busy_cnt <= busy_cnt + 1'b1;
                end
                default: state <= UPD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rtc_flags.sv
// Interrupt flag register with clear-on-read and enable-gated summary.
// A flag event in the same cycle as the read survives the clear.
module rtc_flags
    import rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  flag_t set_in,
    input  flag_t en_in,
    input  logic  rd_clr,
    output flag_t flags,
    output logic  irqf
);

    assign irqf = |(flags & en_in);

    // Accumulate events; a read replaces the contents with new events only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (rd_clr) begin
            flags <= set_in;
        end else begin
            flags <= flags | set_in;
        end
    end

endmodule

// File: rtl/rtc_ctrl.sv
// Real-time clock control core: index/data host access, registers A-D,
// seconds and alarm bytes, byte storage, square-wave and interrupt outputs.
// Assumes bus_wr and bus_rd are never high together and RAM_DEPTH <= 256.
module rtc_ctrl
    import rtc_pkg::*;
#(
    parameter int TICKS_LOG2 = 15,
    parameter int LEAD_TICKS = 8,
    parameter int UPD_TICKS  = 65,
    parameter int RAM_DEPTH  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       sqw
);

    localparam int IDX_W = $clog2(RAM_DEPTH);
    localparam int PAD_W = 8 - IDX_W + 1;

    logic [IDX_W-1:0] idx_q;
    logic [6:0]       reg_a;
    logic [7:0]       reg_b;
    logic [7:0]       sec_q;
    logic [7:0]       alm_q;
    logic [7:0]       ram [RAM_DEPTH];
    logic [7:0]       rd_val;
    logic [7:0]       rdata_q;
    logic             sqw_q;

    logic wr_dat, rd_dat, rd_c;
    logic hit_sec, hit_alm, hit_a, hit_b, hit_c, hit_d, hit_ram;
    logic running, per_pulse, lead_hit, wrap_hit;
    logic uip, sec_step, upd_done;
    logic irqf;
    flag_t flg, flg_set, flg_en;
    logic [2:0] flag_vec, set_vec;

    assign wr_dat  = bus_wr && bus_sel;
    assign rd_dat  = bus_rd && bus_sel;
    assign hit_sec = (idx_q == IDX_W'(IDX_SEC));
    assign hit_alm = (idx_q == IDX_W'(IDX_ALM));
    assign hit_a   = (idx_q == IDX_W'(IDX_A));
    assign hit_b   = (idx_q == IDX_W'(IDX_B));
    assign hit_c   = (idx_q == IDX_W'(IDX_C));
    assign hit_d   = (idx_q == IDX_W'(IDX_D));
    assign hit_ram = !(hit_sec || hit_alm || hit_a || hit_b || hit_c || hit_d);
    assign rd_c    = rd_dat && hit_c;

    rtc_divider #(
        .TICKS_LOG2 (TICKS_LOG2),
        .LEAD_TICKS (LEAD_TICKS)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .div_sel   (reg_a[6:4]),
        .rate      (reg_a[3:0]),
        .running   (running),
        .per_pulse (per_pulse),
        .lead_hit  (lead_hit),
        .wrap_hit  (wrap_hit)
    );

    rtc_update #(
        .UPD_TICKS (UPD_TICKS)
    ) u_upd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .running  (running),
        .halt     (reg_b[B_HALT]),
        .lead_hit (lead_hit),
        .wrap_hit (wrap_hit),
        .uip      (uip),
        .sec_step (sec_step),
        .upd_done (upd_done)
    );

    assign flg_set.pf = per_pulse;
    assign flg_set.af = upd_done && (sec_q == alm_q);
    assign flg_set.uf = upd_done;
    assign flg_en.pf  = reg_b[B_PIE];
    assign flg_en.af  = reg_b[B_AIE];
    assign flg_en.uf  = reg_b[B_UIE];

    rtc_flags u_flg (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (flg_set),
        .en_in  (flg_en),
        .rd_clr (rd_c),
        .flags  (flg),
        .irqf   (irqf)
    );

    assign flag_vec = {flg.pf, flg.af, flg.uf};
    assign set_vec  = {flg_set.pf, flg_set.af, flg_set.uf};

    // Index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (bus_wr && !bus_sel) begin
            idx_q <= bus_wdata[IDX_W-1:0];
        end
    end

    // Control registers A and B
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a <= A_RST;
            reg_b <= B_RST;
        end else if (wr_dat) begin
            if (hit_a) reg_a <= bus_wdata[6:0];
            if (hit_b) reg_b <= bus_wdata;
        end
    end

    // Seconds counter and alarm byte; a host write wins over the update step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            alm_q <= '0;
        end else begin
            if (wr_dat && hit_sec) sec_q <= bus_wdata;
            else if (sec_step)     sec_q <= sec_next(sec_q, reg_b[B_BIN]);
            if (wr_dat && hit_alm) alm_q <= bus_wdata;
        end
    end

    // General byte storage behind the undecoded indices
    always_ff @(posedge clk) begin
        if (wr_dat && hit_ram) ram[idx_q] <= bus_wdata;
    end

    // Data-port read selection
    always_comb begin
        if (hit_sec)      rd_val = sec_q;
        else if (hit_alm) rd_val = alm_q;
        else if (hit_a)   rd_val = {uip, reg_a};
        else if (hit_b)   rd_val = reg_b;
        else if (hit_c)   rd_val = {irqf, flg.pf, flg.af, flg.uf, 4'h0};
        else if (hit_d)   rd_val = D_VAL;
        else              rd_val = ram[idx_q];
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= bus_sel ? rd_val : {{(PAD_W-1){1'b0}}, idx_q};
        end
    end

    // Square wave: toggles on periodic events while enabled, low otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !reg_b[B_SQWE] || (reg_a[3:0] == 4'd0) || !running) begin
            sqw_q <= 1'b0;
        end else if (per_pulse) begin
            sqw_q <= ~sqw_q;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = irqf;
    assign sqw       = sqw_q;

endmodule

// File: rtl/rtc_ctrl_chk.sv
// Property checker for rtc_ctrl, attached through bind.
module rtc_ctrl_chk #(
    parameter int LEAD_TICKS = 8,
    parameter int UPD_TICKS  = 65
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_tick,
    input logic [6:0] reg_a,
    input logic [7:0] reg_b,
    input logic       uip,
    input logic [2:0] flag_vec,
    input logic [2:0] set_vec,
    input logic       rd_c,
    input logic       sqw,
    input logic       irq
);

    localparam logic [15:0] WIN_MAX = 16'(LEAD_TICKS + UPD_TICKS);

    logic [15:0] uip_ticks;

    // Ticks spent in the current in-progress window
    always_ff @(posedge clk) begin
        if (!rst_n || !uip) uip_ticks <= '0;
        else if (ref_tick)  uip_ticks <= uip_ticks + 16'd1;
    end

    AST_HALT_STOPS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_b[7] |=> !uip); // R8
    AST_DIVRST_STOPS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_a[6:5] == 2'b11) |=> !uip); // R5
    AST_RATE0_NO_PF: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_a[3:0] == 4'd0 && !flag_vec[2]) |=> !flag_vec[2]); // R4
    AST_READ_CLEARS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && set_vec == 3'b000) |=> (flag_vec == 3'b000)); // R11
    AST_SQW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_b[3] |=> !sqw); // R13
    AST_UIP_MAX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        uip_ticks <= WIN_MAX); // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_vec != 3'b000)); // R10

endmodule

bind rtc_ctrl rtc_ctrl_chk #(
    .LEAD_TICKS (LEAD_TICKS),
    .UPD_TICKS  (UPD_TICKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .uip      (uip),
    .flag_vec (flag_vec),
    .set_vec  (set_vec),
    .rd_c     (rd_c),
    .sqw      (sqw),
    .irq      (irq)
);

// File: tb/rtc_ctrl_tb.sv
// Self-checking bench for rtc_ctrl with a shortened divider chain.
module rtc_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TLOG2      = 12;
    localparam int LEAD       = 8;
    localparam int UPD        = 65;
    localparam int WD_CYCLES  = 150000;

    typedef struct packed {
        logic [3:0]  rate;
        logic [15:0] period;
    } per_vec_t;

    // Rate code and expected square-wave half period in clocks (R4, R13)
    localparam per_vec_t PER_TAB [6] = '{
        '{4'd1,  16'd1},
        '{4'd2,  16'd2},
        '{4'd3,  16'd4},
        '{4'd5,  16'd16},
        '{4'd8,  16'd128},
        '{4'd11, 16'd1024}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, sqw;

    int n_tests = 0;
    int n_fail  = 0;

    rtc_ctrl #(
        .TICKS_LOG2 (TLOG2),
        .LEAD_TICKS (LEAD),
        .UPD_TICKS  (UPD),
        .RAM_DEPTH  (128)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .sqw       (sqw)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] d);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        bus_write(1'b0, idx);
        bus_write(1'b1, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        bus_write(1'b0, idx);
        bus_sel = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_uip(input logic lvl, output int waited);
        logic [7:0] v;
        waited = 0;
        while (u_dut.uip !== lvl && waited < 10000) begin
            @(negedge clk); waited++;
        end
        v = 8'h00;
    endtask

    task automatic sqw_period(output int per);
        logic last;
        int n = 0;
        last = sqw;
        while (sqw == last && n < 5000) begin @(negedge clk); n++; end
        last = sqw; per = 0;
        while (sqw == last && per < 5000) begin @(negedge clk); per++; end
    endtask

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int per, cnt, highs, toggles;
        logic last;

        repeat (3) @(negedge clk);
        check("R2", "irq in reset", irq, 0);
        check("R2", "sqw in reset", sqw, 0);
        check("R2", "rdata in reset", bus_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        reg_read(8'd10, v); check("R2", "reg A reset", v, 8'h26);
        reg_read(8'd11, v); check("R2", "reg B reset", v, 8'h02);
        reg_read(8'd12, v); check("R2", "reg C reset", v, 8'h00);
        reg_read(8'd13, v); check("R2", "reg D reset", v, 8'h80);

        // R1: byte storage and index read-back
        reg_write(8'h20, 8'h5A);
        reg_write(8'h7F, 8'hC3);
        reg_read(8'h20, v); check("R1", "ram 0x20", v, 8'h5A);
        reg_read(8'h7F, v); check("R1", "ram 0x7F", v, 8'hC3);
        bus_write(1'b0, 8'h33);
        bus_sel = 1'b0; bus_rd = 1'b1; @(negedge clk); bus_rd = 1'b0;
        check("R1", "index read", bus_rdata, 8'h33);

        // R3: bit 7 of A is not writable; R12: D is not writable
        reg_write(8'd10, 8'hA6);
        reg_read(8'd10, v); check("R3", "reg A bit7 write ignored", v, 8'h26);
        reg_write(8'd13, 8'h00);
        reg_read(8'd13, v); check("R12", "reg D write ignored", v, 8'h80);

        // R4/R13: walk the rate table on the square-wave pin
        reg_write(8'd11, 8'h0A);
        foreach (PER_TAB[i]) begin
            reg_write(8'd10, {4'h2, PER_TAB[i].rate});
            sqw_period(per);
            check("R4", $sformatf("sqw half period rate %0d", PER_TAB[i].rate), per, PER_TAB[i].period);
        end

        // R13: rate 0 and disabled output keep the pin low
        reg_write(8'd10, 8'h20);
        toggles = 0;
        repeat (300) begin @(negedge clk); if (sqw) toggles++; end
        check("R13", "sqw high with rate 0", toggles, 0);
        reg_write(8'd11, 8'h02);
        reg_write(8'd10, 8'h21);
        toggles = 0;
        repeat (40) begin @(negedge clk); if (sqw) toggles++; end
        check("R13", "sqw high with output disabled", toggles, 0);

        // R9/R10: periodic flag without enable, then with enable (updates halted)
        reg_write(8'd11, 8'h80);
        reg_write(8'd10, 8'h23);
        reg_read(8'd12, v);
        repeat (10) @(negedge clk);
        check("R10", "irq with PIE off", irq, 0);
        reg_read(8'd12, v); check("R9", "reg C PF only", v, 8'h40);
        reg_write(8'd10, 8'h2C);
        reg_read(8'd12, v);
        reg_write(8'd11, 8'hC0);
        cnt = 0;
        while (!irq && cnt < 5000) begin @(negedge clk); cnt++; end
        check("R10", "irq with PIE on", irq, 1);
        reg_read(8'd12, v); check("R10", "reg C PF with summary", v, 8'hC0);
        check("R11", "irq after read of C", irq, 0);
        reg_read(8'd12, v); check("R11", "reg C cleared by read", v, 8'h00);

        // R6/R7/R9/R10: BCD wrap from 59, alarm match at 00
        reg_write(8'd11, 8'h82);
        reg_write(8'd10, 8'h20);
        reg_write(8'd0, 8'h59);
        reg_write(8'd1, 8'h00);
        reg_read(8'd12, v);
        reg_write(8'd11, 8'h32);
        wait_uip(1'b1, cnt);
        check("R6", "uip rises", u_dut.uip, 1);
        reg_read(8'd0, v); check("R6", "seconds unchanged early in window", v, 8'h59);
        cnt = 3;
        while (cnt < 500) begin
            @(negedge clk);
            if (u_dut.uip) cnt++; else break;
        end
        check("R6", "uip window length", cnt, LEAD + UPD);
        check("R10", "irq after update", irq, 1);
        reg_read(8'd12, v); check("R9", "reg C after update with alarm", v, 8'hB0);
        reg_read(8'd0, v); check("R7", "BCD wrap 59 to 00", v, 8'h00);

        // R3/R7: BCD carry 09 to 10 with in-progress visible in A
        reg_write(8'd11, 8'h82);
        reg_write(8'd0, 8'h09);
        reg_write(8'd11, 8'h02);
        wait_uip(1'b1, cnt);
        reg_read(8'd10, v); check("R3", "reg A shows in-progress", v, 8'hA0);
        wait_uip(1'b0, cnt);
        reg_read(8'd0, v); check("R7", "BCD carry 09 to 10", v, 8'h10);

        // R7: binary wrap 59 to 0
        reg_write(8'd11, 8'h86);
        reg_write(8'd0, 8'h3B);
        reg_write(8'd11, 8'h06);
        wait_uip(1'b1, cnt);
        wait_uip(1'b0, cnt);
        reg_read(8'd0, v); check("R7", "binary wrap 59 to 0", v, 8'h00);

        // R8: halt blocks the update cycle
        reg_write(8'd11, 8'h82);
        reg_write(8'd0, 8'h10);
        reg_read(8'd12, v);
        highs = 0;
        repeat (4500) begin @(negedge clk); if (u_dut.uip) highs++; end
        check("R8", "uip high while halted", highs, 0);
        reg_read(8'd0, v); check("R8", "seconds hold while halted", v, 8'h10);
        reg_read(8'd12, v); check("R8", "no update flag while halted", v, 8'h00);

        // R5: divider reset holds everything still
        reg_write(8'd11, 8'h0A);
        reg_write(8'd10, 8'h63);
        reg_read(8'd12, v);
        highs = 0; toggles = 0; last = sqw;
        repeat (4500) begin
            @(negedge clk);
            if (u_dut.uip) highs++;
            if (sqw != last) toggles++;
            last = sqw;
        end
        check("R5", "uip high in divider reset", highs, 0);
        check("R5", "sqw toggles in divider reset", toggles, 0);
        reg_read(8'd12, v); check("R5", "no flags in divider reset", v, 8'h00);
        reg_write(8'd10, 8'h23);
        repeat (20) @(negedge clk);
        reg_read(8'd12, v); check("R5", "divider runs after release", v, 8'h40);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule